// File: doc/BRIEF.md
# Gshare Branch Direction Predictor with Adjustable History Depth

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. The table index is formed by XORing the word-aligned branch PC with part of an 8-bit global history of recent branch outcomes. A 4-bit control input sets how much of that history enters the hash at run time: all eight bits, a chosen count of the newest bits, or none at all. With no history the predictor behaves as a plain PC-indexed bimodal table.

A fetch stage presents a PC on the predict port and receives the taken/not-taken guess in the same cycle. When a branch resolves, the pipeline presents its PC and real outcome on the update port. The block trains the selected counter and then shifts the outcome into the history. Reset is synchronous and active high.

Top module: `ghist_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken) and the history register holds zero, so every PC predicts not-taken.
- R2: `pred_taken` equals the upper bit of the counter selected by `pred_pc`, the history and `hist_ctl`, and it is valid in the same cycle that `pred_pc` is presented.
- R3: A valid update with `upd_taken`=1 increments the selected counter and saturates it at 3.
- R4: A valid update with `upd_taken`=0 decrements the selected counter and saturates it at 0.
- R5: A valid update shifts `upd_taken` into history bit 0 and discards the oldest bit, bit 7.
- R6: When `hist_ctl[3]` is 1, all eight history bits are used, whatever `hist_ctl[2:0]` holds.
- R7: When `hist_ctl[3]` is 0, `hist_ctl[2:0]` gives a count N from 0 to 7. Only history bits [N-1:0], the N newest outcomes, are used, and the upper bits are taken as zero.
- R8: When `hist_ctl` is 0000, the index comes from the PC alone.
- R9: The index is PC[10:2] XOR the zero-extended masked history. PC bits [1:0] have no effect.
- R10: An update uses the history value held before that same update to form its index.
- R11: A change to `hist_ctl` alters the next prediction and leaves the history and all counters unchanged.
- R12: While `upd_valid` is 0, the counters and the history do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hist_ctl | input | 4 | History depth control: bit 3 selects full history, bits 2:0 give the bit count |
| pred_pc | input | 32 | PC of the branch to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Update strobe |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The bench trains one counter past both ends of its range. A counter that wrapped instead of saturating would flip the prediction after a single opposite outcome. It builds an asymmetric history, then sweeps all sixteen control codes across a block of trained and untrained entries. A mask taken from the wrong end of the history, or one off by a bit, then lands on the wrong counter. Two further single-update cases catch an update indexed with the already-shifted history, and a control change that corrupts stored state. A burst of idle update traffic must leave both the predictions and the history untouched.

// File: rtl/ghist_predictor.sv
module ghist_predictor #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 9,
  parameter int HIST_W = 8,
  parameter int CTL_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CTL_W-1:0] hist_ctl,
  input  logic [PC_W-1:0]  pred_pc,
  output logic             pred_taken,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_taken
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int CNT_W   = 2;
  localparam int N_W     = CTL_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1);

  logic [HIST_W-1:0] ghist, hmask, hused;
  logic [CNT_W-1:0]  ctr [ENTRIES];
  logic [IDX_W-1:0]  pred_idx, upd_idx;
  logic [CNT_W-1:0]  upd_cnt, upd_next;

  assign hmask = hist_ctl[CTL_W-1] ? '1 : ~({HIST_W{1'b1}} << hist_ctl[N_W-1:0]);
  assign hused = ghist & hmask;

  assign pred_idx = pred_pc[IDX_W+1:2] ^ IDX_W'(hused);
  assign upd_idx  = upd_pc[IDX_W+1:2]  ^ IDX_W'(hused);

  assign pred_taken = ctr[pred_idx][CNT_W-1];

  assign upd_cnt  = ctr[upd_idx];
  assign upd_next = upd_taken ? ((upd_cnt == CNT_MAX) ? upd_cnt : upd_cnt + 1'b1)
                              : ((upd_cnt == '0)      ? upd_cnt : upd_cnt - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) ctr[i] <= CNT_INIT;
      ghist <= '0;
    end else if (upd_valid) begin
      ctr[upd_idx] <= upd_next;
      ghist        <= {ghist[HIST_W-2:0], upd_taken};
    end
  end

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc[PC_W-1:IDX_W+2], pred_pc[1:0],
                            upd_pc[PC_W-1:IDX_W+2], upd_pc[1:0]};

  p_hist_shift_r5: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> ghist == {$past(ghist[HIST_W-2:0]), $past(upd_taken)});

  p_hist_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(ghist));

  p_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken && upd_cnt != CNT_MAX) |=>
      ctr[$past(upd_idx)] == $past(upd_cnt) + CNT_W'(1));

  p_sat_top_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken && upd_cnt == CNT_MAX) |=> ctr[$past(upd_idx)] == CNT_MAX);

  p_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken && upd_cnt != '0) |=>
      ctr[$past(upd_idx)] == $past(upd_cnt) - CNT_W'(1));

  p_sat_bot_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken && upd_cnt == '0) |=> ctr[$past(upd_idx)] == '0);
endmodule

// File: tb/ghist_predictor_test.sv
module ghist_predictor_test;
  logic clk = 0, rst = 1, upd_valid = 0, upd_taken = 0, pred_taken;
  logic [3:0]  hist_ctl = 0;
  logic [31:0] pred_pc = 0, upd_pc = 0;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  logic [1:0] mcnt [512];
  logic [7:0] mhist;

  always #2 clk = ~clk;

  ghist_predictor uut (.clk, .rst, .hist_ctl, .pred_pc, .pred_taken,
                       .upd_valid, .upd_pc, .upd_taken);

  function automatic logic [8:0] midx(logic [31:0] pc, logic [7:0] h, logic [3:0] c);
    logic [7:0] m;
    if (c[3]) m = 8'hFF;
    else begin
      m = 0;
      for (int b = 0; b < 8; b++) if (b < int'(c[2:0])) m[b] = 1'b1;
    end
    return pc[10:2] ^ {1'b0, h & m};
  endfunction

  task automatic chk(logic got, logic exp, string req);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s pc=%h ctl=%b got=%b exp=%b", req, pred_pc, hist_ctl, got, exp);
    end
  endtask

  task automatic lit(logic [31:0] pc, logic exp, string req);
    pred_pc = pc; #1; chk(pred_taken, exp, req);
  endtask

  task automatic mchk(logic [31:0] pc, string req);
    pred_pc = pc; #1; chk(pred_taken, mcnt[midx(pc, mhist, hist_ctl)][1], req);
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1; upd_valid = 0;
    @(negedge clk); @(negedge clk); rst = 0;
    for (int i = 0; i < 512; i++) mcnt[i] = 2'b01;
    mhist = 0;
  endtask

  task automatic upd(logic [31:0] pc, logic t);
    logic [8:0] ix;
    @(negedge clk); upd_valid = 1; upd_pc = pc; upd_taken = t;
    @(posedge clk);
    ix = midx(pc, mhist, hist_ctl);
    if (t) mcnt[ix] = (mcnt[ix] == 3) ? 2'd3 : mcnt[ix] + 2'd1;
    else   mcnt[ix] = (mcnt[ix] == 0) ? 2'd0 : mcnt[ix] - 2'd1;
    mhist = {mhist[6:0], t};
    @(negedge clk); upd_valid = 0;
  endtask

  task automatic t_reset;
    do_reset();
    for (int c = 0; c < 16; c += 5) begin
      hist_ctl = 4'(c);
      lit(32'h0, 0, "R1"); lit(32'h7FC, 0, "R1"); lit(32'h1234_5678, 0, "R1");
    end
  endtask

  task automatic t_saturate;
    do_reset(); hist_ctl = 0;
    upd(32'h40, 1); lit(32'h40, 1, "R2 counter 2");
    upd(32'h40, 1); upd(32'h40, 1); upd(32'h40, 1);
    upd(32'h40, 0); lit(32'h40, 1, "R3 saturate at 3");
    upd(32'h40, 0); lit(32'h40, 0, "R4 counter 1");
    upd(32'h40, 0); upd(32'h40, 0); upd(32'h40, 0);
    upd(32'h40, 1); lit(32'h40, 0, "R4 saturate at 0");
    upd(32'h40, 1); lit(32'h40, 1, "R3 climb from 0");
  endtask

  task automatic t_pc_low;
    lit(32'h41, 1, "R9 pc[1:0]"); lit(32'h43, 1, "R9 pc[1:0]");
    lit(32'h840, 1, "R9 pc bit 11 outside index");
    lit(32'h44, 0, "R9 neighbour entry");
  endtask

  task automatic t_pre_hist;
    do_reset(); hist_ctl = 4'b1000;
    upd(32'h0, 1);
    hist_ctl = 4'b0000; lit(32'h0, 1, "R10 pre-update index");
    lit(32'h4, 0, "R8 pc only");
    hist_ctl = 4'b1000; lit(32'h0, 0, "R6 full history");
    lit(32'h4, 1, "R6 full history");
    hist_ctl = 4'b1111; lit(32'h4, 1, "R6 low bits ignored");
    hist_ctl = 4'b0001; lit(32'h4, 1, "R7 one bit");
    hist_ctl = 4'b0000; lit(32'h0, 1, "R11 state kept");
    hist_ctl = 4'b0001; lit(32'h0, 0, "R11 next prediction");
  endtask

  task automatic t_sweep;
    do_reset(); hist_ctl = 0;
    for (int i = 0; i < 16; i++) begin upd(32'(i*4), 1); upd(32'(i*4), 1); end
    for (int i = 0; i < 8; i++) upd(32'h500 + 32'(i*4), 0);
    upd(32'h600, 1); upd(32'h604, 0); upd(32'h608, 0); upd(32'h60C, 1);
    upd(32'h610, 0); upd(32'h614, 1); upd(32'h618, 0); upd(32'h61C, 1);
    for (int c = 0; c < 16; c++) begin
      hist_ctl = 4'(c);
      for (int p = 0; p < 32; p++) mchk(32'(p*4), (c[3] ? "R6 sweep" : (c == 0 ? "R8 sweep" : "R7 sweep")));
    end
  endtask

  task automatic t_idle;
    hist_ctl = 4'b1000;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); upd_valid = 0; upd_pc = 32'(i*4); upd_taken = i[0];
    end
    @(negedge clk);
    for (int p = 0; p < 32; p++) mchk(32'(p*4), "R12 idle update");
    upd(32'h0, 1);
    hist_ctl = 4'b0011;
    for (int p = 0; p < 16; p++) mchk(32'(p*4), "R5 shift");
  endtask

  initial begin
    t_reset();
    t_saturate();
    t_pc_low();
    t_pre_hist();
    t_sweep();
    t_idle();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1; n_vec++; n_bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule